// File: doc/BRIEF.md
# Three-Register Transfer Fabric

This block holds three registers of parameterised width and moves data between them on a single clock. One parameter fixes how the sources reach the destinations. The first option gives each register its own source multiplexer, so any register can load from any other and all three can move in the same cycle. The second option has one shared bus driven by a 2-bit encoded select, so a single source feeds every destination that loads. The third option is the same shared bus, selected by a one-hot set of driver enables. It stands in for a three-state bus and flags driver contention.

A two-register swap request is part of the fabric. It completes in one clock when each register has its own multiplexer. A shared bus cannot carry two sources at once, so in the bus options the request is refused with a flag. A separate initialisation strobe writes a value from outside into any chosen subset of the registers. It wins over every transfer.

Top module: `xfer_regs3`

## Requirements
- R1: An active-low asynchronous reset clears all three registers to zero. While reset is held, the registers stay at zero.
- R2: A register whose load bit `ld[i]` is 0 keeps its value, unless an initialisation or a swap targets it.
- R3: With MODE=0, register i takes the value chosen by its own field `dsel[2i+1:2i]`. Code 0 selects R0, code 1 selects R1, code 2 selects R2, and code 3 selects zero. All three registers may load in the same clock, and each one uses the register values from before that clock edge.
- R4: With MODE=1, `bus_q` carries R0, R1 or R2 for `bsel` codes 0, 1 and 2, and carries zero for code 3. Every register with its load bit set takes `bus_q` at the clock edge.
- R5: With MODE=2, when at most one bit of `drv_en` is set, `bus_q` carries the register whose bit is set (bit i drives Ri), or zero when no bit is set. Loading registers take `bus_q`.
- R6: With MODE=2, when two or more bits of `drv_en` are set, `contention` is 1 in that same cycle. No register loads from the bus in that cycle, and the value on `bus_q` is unspecified.
- R7: With MODE=0, `swap_req` exchanges a pair of registers in one clock. The pair is chosen by `swap_pair`: 0 is R0/R1, 1 is R1/R2, 2 is R0/R2, and 3 is no pair. A swap overrides the load bits and selects of the two registers in the pair.
- R8: With MODE=1 or MODE=2, `swap_req` raises `swap_rej` combinationally and exchanges nothing, while ordinary loads go ahead. With MODE=0, `swap_rej` stays 0.
- R9: When `init_stb` is 1, every register i with `init_mask[i]` set takes `init_data` at the next clock edge. This overrides both swaps and transfers.
- R10: With MODE=0, `bus_q` is zero. Outside MODE=2, `contention` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld | input | 3 | Per-register load enable |
| dsel | input | 6 | Per-register source fields, used in MODE=0 |
| bsel | input | 2 | Encoded bus source, used in MODE=1 |
| drv_en | input | 3 | One-hot bus driver enables, used in MODE=2 |
| swap_req | input | 1 | Request to exchange a register pair |
| swap_pair | input | 2 | Pair chosen for the swap |
| init_stb | input | 1 | Initialisation strobe |
| init_mask | input | 3 | Registers written by the initialisation |
| init_data | input | W | Initialisation value |
| r0 | output | W | Register R0 |
| r1 | output | W | Register R1 |
| r2 | output | W | Register R2 |
| bus_q | output | W | Current shared bus value |
| contention | output | 1 | More than one bus driver enabled |
| swap_rej | output | 1 | Swap refused by a bus topology |

## Verification
The bench builds three copies of the block with W=8, one for each value of MODE (0, 1 and 2), and drives all three with the same stimulus. This lets a single stimulus stream show the concurrency limits side by side. The same cycle loads three destinations from three sources in the multiplexer copy, but only one source reaches every loader in the two bus copies. A swap completes in one copy and is refused in the other two, and a multi-driver enable pattern raises contention only in the one-hot copy. A directed opening covers rotations, swaps, contention, select code 3 and initialisation overriding a swap. Pseudo-random cycles follow it.

// File: rtl/xfer_regs3.sv
`timescale 1ns/1ps
module xfer_regs3 #(
  parameter int W    = 8,
  parameter int MODE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   ld,
  input  logic [5:0]   dsel,
  input  logic [1:0]   bsel,
  input  logic [2:0]   drv_en,
  input  logic         swap_req,
  input  logic [1:0]   swap_pair,
  input  logic         init_stb,
  input  logic [2:0]   init_mask,
  input  logic [W-1:0] init_data,
  output logic [W-1:0] r0,
  output logic [W-1:0] r1,
  output logic [W-1:0] r2,
  output logic [W-1:0] bus_q,
  output logic         contention,
  output logic         swap_rej
);

  localparam logic DEDICATED = (MODE == 0);

  logic [W-1:0] q [3];
  logic [W-1:0] enc_bus, hot_bus;
  logic         multi_drv;
  logic [2:0]   swap_hit;
  logic [1:0]   partner [3];

  function automatic logic [W-1:0] pick(input logic [1:0] c,
                                        input logic [W-1:0] a0,
                                        input logic [W-1:0] a1,
                                        input logic [W-1:0] a2);
    case (c)
      2'd0:    pick = a0;
      2'd1:    pick = a1;
      2'd2:    pick = a2;
      default: pick = '0;
    endcase
  endfunction

  assign enc_bus   = pick(bsel, q[0], q[1], q[2]);
  assign hot_bus   = ({W{drv_en[0]}} & q[0]) | ({W{drv_en[1]}} & q[1]) | ({W{drv_en[2]}} & q[2]);
  assign multi_drv = (drv_en[0] & drv_en[1]) | (drv_en[0] & drv_en[2]) | (drv_en[1] & drv_en[2]);

  assign contention = (MODE == 2) && multi_drv;
  assign bus_q      = (MODE == 1) ? enc_bus : (MODE == 2) ? hot_bus : '0;
  assign swap_rej   = swap_req && !DEDICATED;

  always_comb begin
    swap_hit = '0;
    partner[0] = 2'd0;
    partner[1] = 2'd1;
    partner[2] = 2'd2;
    if (DEDICATED && swap_req) begin
      case (swap_pair)
        2'd0: begin swap_hit = 3'b011; partner[0] = 2'd1; partner[1] = 2'd0; end
        2'd1: begin swap_hit = 3'b110; partner[1] = 2'd2; partner[2] = 2'd1; end
        2'd2: begin swap_hit = 3'b101; partner[0] = 2'd2; partner[2] = 2'd0; end
        default: swap_hit = '0;
      endcase
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_reg
    logic [W-1:0] own_src, nxt;

    assign own_src = pick(dsel[2*i +: 2], q[0], q[1], q[2]);

    always_comb begin
      nxt = q[i];
      if (init_stb && init_mask[i])
        nxt = init_data;
      else if (swap_hit[i])
        nxt = pick(partner[i], q[0], q[1], q[2]);
      else if (ld[i]) begin
        if (DEDICATED)
          nxt = own_src;
        else if (!contention)
          nxt = bus_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q[i] <= '0;
      else        q[i] <= nxt;
  end

  assign r0 = q[0];
  assign r1 = q[1];
  assign r2 = q[2];

endmodule

// File: rtl/xfer_regs3_chk.sv
`timescale 1ns/1ps
module xfer_regs3_chk #(
  parameter int W    = 8,
  parameter int MODE = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   ld,
  input logic [2:0]   drv_en,
  input logic         swap_req,
  input logic [1:0]   swap_pair,
  input logic         init_stb,
  input logic [2:0]   init_mask,
  input logic [W-1:0] init_data,
  input logic [W-1:0] r0,
  input logic [W-1:0] r1,
  input logic [W-1:0] r2,
  input logic [W-1:0] bus_q,
  input logic         contention,
  input logic         swap_rej
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_stb && ld == 3'b000 && !swap_req) |=> ($stable(r0) && $stable(r1) && $stable(r2)));

  a_r9_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (init_stb && init_mask[1]) |=> (r1 == $past(init_data)));

  a_r7_swap01: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && swap_req && swap_pair == 2'd0 && !init_stb) |=> (r0 == $past(r1) && r1 == $past(r0)));

  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE != 0 && swap_req) |-> swap_rej);

  a_r4_shared_src: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE != 0 && !init_stb && ld[0] && ld[2] && !contention) |=> (r0 == r2));

  a_r6_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (contention && ld[1] && !init_stb) |=> $stable(r1));

  a_r5_single_drv: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 2 && drv_en == 3'b010) |-> (bus_q == r1));

endmodule

bind xfer_regs3 xfer_regs3_chk #(.W(W), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .drv_en(drv_en), .swap_req(swap_req),
  .swap_pair(swap_pair), .init_stb(init_stb), .init_mask(init_mask),
  .init_data(init_data), .r0(r0), .r1(r1), .r2(r2), .bus_q(bus_q),
  .contention(contention), .swap_rej(swap_rej)
);

// File: tb/xfer_regs3_test.sv
`timescale 1ns/1ps
module xfer_regs3_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [2:0]   ld, drv_en, init_mask;
  logic [5:0]   dsel;
  logic [1:0]   bsel, swap_pair;
  logic         swap_req, init_stb;
  logic [W-1:0] init_data;

  logic [2:0]   s_ld, s_en, s_mask;
  logic [5:0]   s_dsel;
  logic [1:0]   s_bsel, s_pair;
  logic         s_sw, s_init;
  logic [W-1:0] s_data;

  logic [W-1:0] o0 [3], o1 [3], o2 [3], ob [3];
  logic         oc [3], orj [3];

  xfer_regs3 #(.W(W), .MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .dsel(dsel), .bsel(bsel), .drv_en(drv_en),
    .swap_req(swap_req), .swap_pair(swap_pair), .init_stb(init_stb),
    .init_mask(init_mask), .init_data(init_data), .r0(o0[0]), .r1(o1[0]),
    .r2(o2[0]), .bus_q(ob[0]), .contention(oc[0]), .swap_rej(orj[0]));

  xfer_regs3 #(.W(W), .MODE(1)) uut_bus (
    .clk(clk), .rst_n(rst_n), .ld(ld), .dsel(dsel), .bsel(bsel), .drv_en(drv_en),
    .swap_req(swap_req), .swap_pair(swap_pair), .init_stb(init_stb),
    .init_mask(init_mask), .init_data(init_data), .r0(o0[1]), .r1(o1[1]),
    .r2(o2[1]), .bus_q(ob[1]), .contention(oc[1]), .swap_rej(orj[1]));

  xfer_regs3 #(.W(W), .MODE(2)) uut_hot (
    .clk(clk), .rst_n(rst_n), .ld(ld), .dsel(dsel), .bsel(bsel), .drv_en(drv_en),
    .swap_req(swap_req), .swap_pair(swap_pair), .init_stb(init_stb),
    .init_mask(init_mask), .init_data(init_data), .r0(o0[2]), .r1(o1[2]),
    .r2(o2[2]), .bus_q(ob[2]), .contention(oc[2]), .swap_rej(orj[2]));

  logic [W-1:0] m  [3][3];
  logic [W-1:0] nx [3][3];
  string        ltag [3];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int md, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s mode %0d: got %0h expected %0h", req, md, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sel3(input int md, input logic [1:0] c);
    return (c < 2'd3) ? m[md][c] : '0;
  endfunction

  task automatic cycle();
    @(negedge clk);
    for (int md = 0; md < 3; md++) begin
      chk(o0[md] == m[md][0], ltag[md], md, o0[md], m[md][0]);
      chk(o1[md] == m[md][1], ltag[md], md, o1[md], m[md][1]);
      chk(o2[md] == m[md][2], ltag[md], md, o2[md], m[md][2]);
    end
    ld = s_ld; dsel = s_dsel; bsel = s_bsel; drv_en = s_en;
    swap_req = s_sw; swap_pair = s_pair; init_stb = s_init;
    init_mask = s_mask; init_data = s_data;
    #1;
    for (int md = 0; md < 3; md++) begin
      logic [W-1:0] busv;
      logic         cont;
      int           cnt;
      cnt  = $countones(s_en);
      cont = (md == 2) && (cnt > 1);
      busv = '0;
      if (md == 1) busv = sel3(1, s_bsel);
      if (md == 2) for (int i = 0; i < 3; i++) if (s_en[i]) busv = busv | m[2][i];
      if (!cont)
        chk(ob[md] == busv, md == 0 ? "R10" : (md == 1 ? "R4" : "R5"), md, ob[md], busv);
      chk(oc[md] == cont, md == 2 ? "R6" : "R10", md, oc[md], cont);
      chk(orj[md] == (s_sw && md != 0), "R8", md, orj[md], (s_sw && md != 0));
      for (int i = 0; i < 3; i++) begin
        int other;
        other = -1;
        if (md == 0 && s_sw) begin
          case (s_pair)
            2'd0: other = (i == 0) ? 1 : (i == 1) ? 0 : -1;
            2'd1: other = (i == 1) ? 2 : (i == 2) ? 1 : -1;
            2'd2: other = (i == 0) ? 2 : (i == 2) ? 0 : -1;
            default: other = -1;
          endcase
        end
        nx[md][i] = m[md][i];
        if (!rst_n)                         nx[md][i] = '0;
        else if (s_init && s_mask[i])       nx[md][i] = s_data;
        else if (other >= 0)                nx[md][i] = m[md][other];
        else if (s_ld[i]) begin
          if (md == 0)                      nx[md][i] = sel3(0, s_dsel[2*i +: 2]);
          else if (!cont)                   nx[md][i] = busv;
        end
      end
      if (!rst_n)                 ltag[md] = "R1";
      else if (s_init)            ltag[md] = "R9";
      else if (s_sw && md == 0)   ltag[md] = "R7";
      else if (s_ld == 3'b000)    ltag[md] = "R2";
      else if (cont)              ltag[md] = "R6";
      else                        ltag[md] = (md == 0) ? "R3" : (md == 1) ? "R4" : "R5";
    end
    @(posedge clk);
    #1;
    m = nx;
  endtask

  task automatic stage(input logic [2:0] l, input logic [5:0] ds, input logic [1:0] bs,
                       input logic [2:0] en, input logic sw, input logic [1:0] pr,
                       input logic it, input logic [2:0] mk, input logic [W-1:0] dt);
    s_ld = l; s_dsel = ds; s_bsel = bs; s_en = en; s_sw = sw; s_pair = pr;
    s_init = it; s_mask = mk; s_data = dt;
    cycle();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ld = '0; dsel = '0; bsel = '0; drv_en = '0; swap_req = 1'b0; swap_pair = '0;
    init_stb = 1'b0; init_mask = '0; init_data = '0;
    for (int md = 0; md < 3; md++) begin
      ltag[md] = "R1";
      for (int i = 0; i < 3; i++) m[md][i] = '0;
    end
    stage(3'b111, 6'b011001, 2'd1, 3'b001, 1'b0, 2'd0, 1'b1, 3'b111, 8'h5A);
    stage(3'b111, 6'b011001, 2'd1, 3'b001, 1'b0, 2'd0, 1'b1, 3'b111, 8'h5A);
    rst_n = 1'b1;
    stage(3'b000, '0, 2'd0, 3'b000, 1'b0, 2'd0, 1'b1, 3'b001, 8'hA1);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b0, 2'd0, 1'b1, 3'b010, 8'hB2);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b0, 2'd0, 1'b1, 3'b100, 8'hC3);
    stage(3'b000, '0, 2'd2, 3'b100, 1'b0, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b111, 6'b001001, 2'd2, 3'b100, 1'b0, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b1, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b100, 6'b110000, 2'd0, 3'b001, 1'b1, 2'd1, 1'b0, 3'b000, 8'h00);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b0, 2'd0, 1'b1, 3'b111, 8'h3C);
    stage(3'b011, 6'b000110, 2'd2, 3'b100, 1'b0, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b111, 6'b111111, 2'd3, 3'b011, 1'b0, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b0, 2'd0, 1'b1, 3'b011, 8'h77);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b1, 2'd2, 1'b1, 3'b001, 8'hE4);
    stage(3'b111, 6'b000000, 2'd0, 3'b111, 1'b0, 2'd0, 1'b0, 3'b000, 8'h00);
    stage(3'b000, '0, 2'd0, 3'b000, 1'b1, 2'd3, 1'b0, 3'b000, 8'h00);
    for (int n = 0; n < 1500; n++) begin
      stage(3'($urandom), 6'($urandom), 2'($urandom), 3'($urandom),
            ($urandom % 4) == 0, 2'($urandom), ($urandom % 6) == 0,
            3'($urandom), 8'($urandom));
    end
    @(negedge clk);
    for (int md = 0; md < 3; md++) begin
      chk(o0[md] == m[md][0], ltag[md], md, o0[md], m[md][0]);
      chk(o1[md] == m[md][1], ltag[md], md, o1[md], m[md][1]);
      chk(o2[md] == m[md][2], ltag[md], md, o2[md], m[md][2]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule